// File: doc/BRIEF.md
# Credit-Gated Memory-Mapped Write Bridge

The bridge takes memory-mapped write requests from a processor store port and turns them into write packets on a link transmit port. Requests go into a small in-order queue. A packet can leave the queue only while the link partner has granted a transmit credit. Credits are used up as packets are sent and come back on a one-bit return strobe. A write is never dropped. When credits run out, packets wait in the queue until credits return.

Retirement depends on the write class. A posted write is finished as soon as its packet is handed to the transmit port, and no completion is expected for it. A non-posted write holds the requester until a completion with a matching tag comes back. A deferrable write works the same way as a non-posted write, but its completion also carries an accept-or-retry result, and the bridge hands that result to the requester as a single flag.

A three-state tracker follows the single outstanding non-posted or deferrable request:
- `TR_IDLE` moves to `TR_QUEUED` when such a store is accepted.
- `TR_QUEUED` moves to `TR_WAIT` when its packet is sent.
- `TR_WAIT` returns to `TR_IDLE` when a completion with the matching tag arrives.

While the tracker is not in `TR_IDLE`, the store port is stalled.

Top module: `mmio_wr_bridge`

## Requirements
- R1: After reset, `st_ready` is 1 and `tx_valid`, `st_done`, `st_retry`, `cr_ovf` and `cpl_bad` are 0. A store is accepted in the cycle it is offered when the queue (QDEPTH entries, default 4) is not full and no non-posted request is pending. With QDEPTH entries queued, `st_ready` is 0.
- R2: `tx_valid` is 1 only while the queue is non-empty and the credit count is above zero. After CREDITS (default 8) packets are sent with no return, further queued packets wait with `tx_valid` at 0.
- R3: Each cycle with `cr_ret` high adds one credit, and each transfer (`tx_valid && tx_ready`) removes one. When both happen in the same cycle, the count is unchanged.
- R4: The credit count never rises above CREDITS. A `cr_ret` that would take it past CREDITS is discarded, and `cr_ovf` is 1 for exactly the following cycle.
- R5: Packets leave in store order with the kind, address and data of the store. While `tx_valid` is high and `tx_ready` is low, the packet fields stay stable.
- R6: Kind 0 is a posted write. The cycle after its transfer, `st_done` is 1 and `st_retry` is 0.
- R7: Kinds 1 (non-posted), 2 (deferrable) and 3 (treated as non-posted) drop `st_ready` from the cycle after acceptance. `st_ready` stays low until the cycle after a matching completion, which is also the cycle in which `st_done` is 1.
- R8: For a deferrable write, `st_retry` equals `cpl_retry` of the matching completion, shown together with `st_done`. For any other kind, `st_retry` stays 0.
- R9: Non-posted and deferrable packets carry `tx_tag` values 0, 1, 2, … in issue order. A completion that arrives while no request is awaiting one, or whose tag differs from the outstanding tag, is discarded: `cpl_bad` is 1 the next cycle and the requester stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_kind | input | 2 | 0 posted, 1 non-posted, 2 deferrable, 3 non-posted |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_done | output | 1 | Store retired (one-cycle pulse) |
| st_retry | output | 1 | Deferrable store rejected for retry, valid with `st_done` |
| tx_valid | output | 1 | Packet available |
| tx_ready | input | 1 | Link takes the packet |
| tx_kind | output | 2 | Packet write class |
| tx_addr | output | ADDR_W | Packet address |
| tx_data | output | DATA_W | Packet data |
| tx_tag | output | TAG_W | Tag of a non-posted packet |
| cr_ret | input | 1 | One credit returned |
| cr_ovf | output | 1 | Excess credit return discarded |
| cpl_valid | input | 1 | Completion received |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_retry | input | 1 | Completion reports retry |
| cpl_bad | output | 1 | Completion discarded |

## Verification
A table of six stores mixes posted, non-posted and deferrable kinds, some with retry set in their completion. This separates retirement on send from retirement on completion, and shows that the retry flag passes through only for the deferrable class. Directed runs then cover the remaining corner cases:
- filling the queue against a stalled link, which exposes both full-queue stalling and in-order draining;
- sending a burst with no credits returned, which shows the credit gate, a return in the same cycle as a transfer, and saturation on excess returns;
- completions that are unexpected or carry a wrong tag, which must be rejected without releasing the requester.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
    typedef enum logic [1:0] {
        WK_POSTED  = 2'd0,
        WK_NONPOST = 2'd1,
        WK_DEFER   = 2'd2,
        WK_RSVD    = 2'd3
    } wkind_e;
endpackage

// File: rtl/wbr_fifo.sv
module wbr_fifo #(
    parameter int W     = 66,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign head  = mem[rd_ptr];
    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
endmodule

// File: rtl/wbr_credit.sv
module wbr_credit #(
    parameter int CREDITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic have,
    output logic ovf
);
    localparam int CW = $clog2(CREDITS + 1);

    logic [CW-1:0] count;
    logic          ovf_q;
    logic          at_top;
    logic          lost;

    assign at_top = (count == CW'(CREDITS));
    assign lost   = give && at_top && !take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CW'(CREDITS);
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= lost;
            unique case ({take, give})
                2'b10:   count <= count - 1'b1;
                2'b01:   count <= at_top ? count : count + 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign have = (count != '0);
    assign ovf  = ovf_q;
endmodule

// File: rtl/wbr_track.sv
module wbr_track #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             np_accept,
    input  logic             np_defer,
    input  logic             np_sent,
    input  logic             posted_sent,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             cpl_retry,
    output logic             hold,
    output logic [TAG_W-1:0] tag,
    output logic             done,
    output logic             retry,
    output logic             bad
);
    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_QUEUED = 2'd1,
        TR_WAIT   = 2'd2
    } tr_state_e;

    tr_state_e        state_q, state_d;
    logic [TAG_W-1:0] next_tag_q, wait_tag_q;
    logic             defer_q;
    logic             hit;
    logic             done_q, retry_q, bad_q;

    assign hit = cpl_valid && (state_q == TR_WAIT) && (cpl_tag == wait_tag_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TR_IDLE:   if (np_accept) state_d = TR_QUEUED;
            TR_QUEUED: if (np_sent)   state_d = TR_WAIT;
            TR_WAIT:   if (hit)       state_d = TR_IDLE;
            default:                  state_d = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_tag_q <= '0;
            wait_tag_q <= '0;
            defer_q    <= 1'b0;
        end else begin
            if (np_accept) defer_q <= np_defer;
            if (np_sent) begin
                wait_tag_q <= next_tag_q;
                next_tag_q <= next_tag_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            retry_q <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            done_q  <= posted_sent || hit;
            retry_q <= hit && defer_q && cpl_retry;
            bad_q   <= cpl_valid && !hit;
        end
    end

    assign hold  = (state_q != TR_IDLE);
    assign tag   = next_tag_q;
    assign done  = done_q;
    assign retry = retry_q;
    assign bad   = bad_q;
endmodule

// File: rtl/mmio_wr_bridge.sv
module mmio_wr_bridge
    import wbr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int QDEPTH  = 4,
    parameter int CREDITS = 8,
    parameter int TAG_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [1:0]        st_kind,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_done,
    output logic              st_retry,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [1:0]        tx_kind,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    output logic [TAG_W-1:0]  tx_tag,
    input  logic              cr_ret,
    output logic              cr_ovf,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              cpl_retry,
    output logic              cpl_bad
);
    localparam int EW = 2 + ADDR_W + DATA_W;

    logic [EW-1:0] q_head;
    logic          q_full, q_empty;
    logic          push, fire, have_credit, hold;
    logic          head_posted, in_posted;

    assign push      = st_valid && st_ready;
    assign fire      = tx_valid && tx_ready;
    assign in_posted = (st_kind == WK_POSTED);

    wbr_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (fire),
        .din   ({st_kind, st_addr, st_data}),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    wbr_credit #(.CREDITS(CREDITS)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (fire),
        .give  (cr_ret),
        .have  (have_credit),
        .ovf   (cr_ovf)
    );

    assign tx_kind     = q_head[EW-1 -: 2];
    assign tx_addr     = q_head[DATA_W +: ADDR_W];
    assign tx_data     = q_head[DATA_W-1:0];
    assign head_posted = (tx_kind == WK_POSTED);
    assign tx_valid    = !q_empty && have_credit;

    wbr_track #(.TAG_W(TAG_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .np_accept   (push && !in_posted),
        .np_defer    (st_kind == WK_DEFER),
        .np_sent     (fire && !head_posted),
        .posted_sent (fire && head_posted),
        .cpl_valid   (cpl_valid),
        .cpl_tag     (cpl_tag),
        .cpl_retry   (cpl_retry),
        .hold        (hold),
        .tag         (tx_tag),
        .done        (st_done),
        .retry       (st_retry),
        .bad         (cpl_bad)
    );

    assign st_ready = !q_full && !hold;
endmodule

// File: rtl/mmio_wr_bridge_chk.sv
module mmio_wr_bridge_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CREDITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [1:0]        st_kind,
    input logic              st_done,
    input logic              st_retry,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [1:0]        tx_kind,
    input logic [ADDR_W-1:0] tx_addr,
    input logic [DATA_W-1:0] tx_data,
    input logic              cr_ret,
    input logic              cr_ovf,
    input logic              cpl_valid,
    input logic              cpl_bad
);
    localparam int CW = $clog2(CREDITS + 1);

    logic [CW-1:0] seen_credit;
    logic          xfer;

    assign xfer = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_credit <= CW'(CREDITS);
        else if (xfer && !cr_ret) seen_credit <= seen_credit - 1'b1;
        else if (!xfer && cr_ret && seen_credit != CW'(CREDITS))
            seen_credit <= seen_credit + 1'b1;
    end

    assert_credit_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (seen_credit != '0));

    assert_tx_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_data) && $stable(tx_kind)));

    assert_np_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_kind != 2'd0) |=> !st_ready);

    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cr_ovf |-> $past(cr_ret));

    assert_retry_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_retry |-> st_done);

    assert_bad_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_bad |-> $past(cpl_valid));
endmodule

bind mmio_wr_bridge mmio_wr_bridge_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CREDITS (CREDITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_kind   (st_kind),
    .st_done   (st_done),
    .st_retry  (st_retry),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_kind   (tx_kind),
    .tx_addr   (tx_addr),
    .tx_data   (tx_data),
    .cr_ret    (cr_ret),
    .cr_ovf    (cr_ovf),
    .cpl_valid (cpl_valid),
    .cpl_bad   (cpl_bad)
);

// File: tb/mmio_wr_bridge_tb.sv
module mmio_wr_bridge_tb;
    localparam int PERIOD  = 10;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int TAG_W   = 4;
    localparam int NVEC    = 6;

    localparam logic [1:0]  V_KIND [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1};
    localparam logic [31:0] V_ADDR [NVEC] = '{32'h1000, 32'h1004, 32'h2000, 32'h1008, 32'h2004, 32'h100C};
    localparam logic [31:0] V_DATA [NVEC] = '{32'hA5A5_0001, 32'h0000_BEEF, 32'h1234_5678, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hCAFE_F00D};
    localparam logic        V_RTY  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              st_valid, st_ready;
    logic [1:0]        st_kind;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic              st_done, st_retry;
    logic              tx_valid, tx_ready;
    logic [1:0]        tx_kind;
    logic [ADDR_W-1:0] tx_addr;
    logic [DATA_W-1:0] tx_data;
    logic [TAG_W-1:0]  tx_tag;
    logic              cr_ret, cr_ovf;
    logic              cpl_valid, cpl_retry, cpl_bad;
    logic [TAG_W-1:0]  cpl_tag;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_tag = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    mmio_wr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(4), .CREDITS(8), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_kind(st_kind),
        .st_addr(st_addr), .st_data(st_data), .st_done(st_done), .st_retry(st_retry),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
        .tx_addr(tx_addr), .tx_data(tx_data), .tx_tag(tx_tag),
        .cr_ret(cr_ret), .cr_ovf(cr_ovf),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_retry(cpl_retry), .cpl_bad(cpl_bad)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; st_valid = 0; st_kind = 0; st_addr = 0; st_data = 0;
        tx_ready = 0; cr_ret = 0; cpl_valid = 0; cpl_tag = 0; cpl_retry = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        chk("R1 reset st_ready", 64'(st_ready), 64'd1);
        chk("R1 reset tx_valid", 64'(tx_valid), 64'd0);
        chk("R1 reset st_done", 64'(st_done), 64'd0);
        chk("R1 reset st_retry", 64'(st_retry), 64'd0);
        chk("R1 reset cr_ovf", 64'(cr_ovf), 64'd0);
        chk("R1 reset cpl_bad", 64'(cpl_bad), 64'd0);

        // table walk: mixed write classes, credit returned after each send
        tx_ready = 1;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            st_valid = 1; st_kind = V_KIND[i]; st_addr = V_ADDR[i]; st_data = V_DATA[i];
            #1 chk("R1 accept", 64'(st_ready), 64'd1);
            @(negedge clk);
            st_valid = 0;
            #1;
            chk("R5 tx_valid", 64'(tx_valid), 64'd1);
            chk("R5 tx_kind", 64'(tx_kind), 64'(V_KIND[i]));
            chk("R5 tx_addr", 64'(tx_addr), 64'(V_ADDR[i]));
            chk("R5 tx_data", 64'(tx_data), 64'(V_DATA[i]));
            if (V_KIND[i] != 2'd0) begin
                chk("R9 tx_tag", 64'(tx_tag), 64'(exp_tag));
                chk("R7 stalled", 64'(st_ready), 64'd0);
            end
            @(negedge clk);
            cr_ret = 1;
            #1;
            if (V_KIND[i] == 2'd0) begin
                chk("R6 posted done", 64'(st_done), 64'd1);
                chk("R6 posted retry", 64'(st_retry), 64'd0);
                @(negedge clk);
                cr_ret = 0;
            end else begin
                chk("R7 no done before cpl", 64'(st_done), 64'd0);
                chk("R7 still stalled", 64'(st_ready), 64'd0);
                cpl_valid = 1; cpl_tag = TAG_W'(exp_tag); cpl_retry = V_RTY[i];
                @(negedge clk);
                cr_ret = 0; cpl_valid = 0; cpl_retry = 0;
                #1;
                chk("R7 done on cpl", 64'(st_done), 64'd1);
                chk("R8 retry flag", 64'(st_retry), 64'((V_KIND[i] == 2'd2) ? V_RTY[i] : 1'b0));
                chk("R7 released", 64'(st_ready), 64'd1);
                exp_tag++;
            end
        end

        // unexpected completion while idle
        @(negedge clk);
        cpl_valid = 1; cpl_tag = 4'h9;
        @(negedge clk);
        cpl_valid = 0;
        #1 chk("R9 unexpected cpl", 64'(cpl_bad), 64'd1);

        // wrong tag then right tag
        @(negedge clk);
        st_valid = 1; st_kind = 2'd1; st_addr = 32'h3000; st_data = 32'h55;
        @(negedge clk);
        st_valid = 0;
        @(negedge clk);
        cr_ret = 1;
        cpl_valid = 1; cpl_tag = TAG_W'(exp_tag + 1);
        @(negedge clk);
        cr_ret = 0;
        cpl_tag = TAG_W'(exp_tag);
        #1;
        chk("R9 bad tag flagged", 64'(cpl_bad), 64'd1);
        chk("R9 bad tag no done", 64'(st_done), 64'd0);
        chk("R9 bad tag still stalled", 64'(st_ready), 64'd0);
        @(negedge clk);
        cpl_valid = 0;
        #1;
        chk("R9 good tag done", 64'(st_done), 64'd1);
        chk("R9 good tag not bad", 64'(cpl_bad), 64'd0);
        exp_tag++;

        // queue full against a stalled link
        @(negedge clk);
        tx_ready = 0;
        st_valid = 1; st_kind = 2'd0;
        for (int k = 0; k < 4; k++) begin
            st_addr = 32'h100 + 32'(k); st_data = 32'(k);
            #1 chk("R1 queue accept", 64'(st_ready), 64'd1);
            @(negedge clk);
        end
        st_addr = 32'h104;
        #1;
        chk("R1 queue full stall", 64'(st_ready), 64'd0);
        chk("R5 head held", 64'(tx_addr), 64'h100);
        @(negedge clk);
        st_valid = 0;
        tx_ready = 1;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R5 order valid", 64'(tx_valid), 64'd1);
            chk("R5 order addr", 64'(tx_addr), 64'h100 + 64'(k));
            @(negedge clk);
        end
        cr_ret = 1;
        repeat (4) @(negedge clk);
        cr_ret = 0;

        // credit exhaustion
        st_valid = 1; st_kind = 2'd0;
        for (int k = 0; k < 9; k++) begin
            st_addr = 32'h200 + 32'(k);
            @(negedge clk);
        end
        st_valid = 0;
        repeat (2) @(negedge clk);
        #1;
        chk("R2 no credit no send", 64'(tx_valid), 64'd0);
        chk("R2 waiting packet", 64'(tx_addr), 64'h208);
        @(negedge clk);
        st_valid = 1; st_addr = 32'h209;
        @(negedge clk);
        st_valid = 0;
        cr_ret = 1;
        @(negedge clk);
        #1;
        chk("R3 credit restores", 64'(tx_valid), 64'd1);
        chk("R3 restored packet", 64'(tx_addr), 64'h208);
        @(negedge clk);
        cr_ret = 0;
        #1;
        chk("R3 same-cycle return", 64'(tx_valid), 64'd1);
        chk("R3 next packet", 64'(tx_addr), 64'h209);
        @(negedge clk);
        #1 chk("R2 spent again", 64'(tx_valid), 64'd0);

        // saturation and overflow flag
        @(negedge clk);
        cr_ret = 1;
        repeat (8) @(negedge clk);
        #1 chk("R4 no ovf at top", 64'(cr_ovf), 64'd0);
        @(negedge clk);
        cr_ret = 0;
        #1 chk("R4 ovf pulse", 64'(cr_ovf), 64'd1);
        @(negedge clk);
        #1 chk("R4 ovf one cycle", 64'(cr_ovf), 64'd0);

        st_valid = 1; st_kind = 2'd0;
        for (int k = 0; k < 9; k++) begin
            st_addr = 32'h400 + 32'(k);
            @(negedge clk);
        end
        st_valid = 0;
        repeat (2) @(negedge clk);
        #1;
        chk("R4 saturated at limit", 64'(tx_valid), 64'd0);
        chk("R4 ninth waits", 64'(tx_addr), 64'h408);

        finish_run();
    end
endmodule